// File: doc/BRIEF.md
# Keyed Watchdog Timer with Pre-Timeout Interrupt

This block is a memory-mapped watchdog timer. Software programs a timeout period, enables the timer and must then feed it regularly. If software stops feeding it, the timer expires. In single mode, expiry drives an external reset pulse. In dual mode, the first expiry raises an interrupt that warns software, and a second expiry with no feed in between drives the reset pulse. Every write that changes state has to carry a value or key field tied to its register. A write with the wrong key is dropped, so a stray store cannot reprogram, feed or fire the watchdog.

The counter advances on a slow tick, which reaches the block as a one-cycle enable (`tick_en`) in the bus clock domain. One unit of the period field equals 512 ticks, which is 1/64 s of a 32 kHz tick. A keyed write can also fire the reset at once. A further keyed register holds a vector of reset lines that other blocks use; each line is held for as long as its bit is set. Reads return the stored contents, and every key field reads as zero.

Top module: `keyed_wdog`

## Requirements
- R1: The control register (offset 0x00) accepts a write only when wdata[31:24] is 0x22. Otherwise it keeps its value. Its fields are enable (bit 0), reset polarity (bit 1, 1 = active high), external reset drive (bit 2), interrupt enable (bit 3), auto-start (bit 4, stored only) and dual mode (bit 6). It resets to zero.
- R2: The period register (offset 0x04) takes the count from wdata[15:5], and only when wdata[4:0] is 0x08. It resets to all ones.
- R3: While enabled, with the counter reloaded to N = count×512 ticks, the N-th tick expires the counter. In single mode, expiry starts a reset pulse in the cycle after that tick's edge, and the counter reloads.
- R4: A write of exactly 0x00001971 to offset 0x08 reloads the counter and clears the interrupt. Any other value written there has no effect.
- R5: A write of exactly 0x00001209 to offset 0x14 starts the reset pulse at once, even while the timer is disabled. Any other value has no effect.
- R6: In dual mode with interrupt enable set, the first expiry raises `irq` and reloads the counter. The next expiry with no feed in between starts the reset pulse.
- R7: Once raised, `irq` stays high until a feed, or until enable is cleared; it is low in the cycle after either.
- R8: The reset pulse lasts exactly 16 cycles. `rst_out` shows the active level set by the polarity bit only while external reset drive is set, and shows the inactive level otherwise.
- R9: The block reset vector (offset 0x18) loads wdata[15:0] only when wdata[31:24] is 0x88. Each set bit holds `blk_rst` for that line high, and a cleared bit releases it.
- R10: The counter advances only on ticks while enable is set. Clearing enable stops it with no reset, and setting enable again starts a full period.
- R11: An accepted period write reloads the counter with the new count.
- R12: A read returns data one cycle after `rd_en`. Control reads as {dual, 0, auto, irq_en, drive, polarity, enable} in bits 6:0. The period reads as its count in bits 15:5 with zeros below. The vector reads in bits 15:0. Offsets 0x08 and 0x14 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle pulse per slow tick |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| irq | output | 1 | Pre-timeout interrupt |
| rst_out | output | 1 | External reset, polarity programmable |
| blk_rst | output | 16 | Held resets for other blocks |

## Verification
Expiry is tried in four ways: free-running single mode, a feed in mid-period, a period rewrite in mid-period, and a stretch with ticks held off. Each places the reset edge at a different cycle, so an off-by-one in the reload, a missing reload or counting without ticks shows up as a pulse on the wrong cycle. Dual mode is run through both stages, and then cleared by a feed and by a disable, to separate the interrupt stage from the reset stage. Every keyed register also receives near-miss values, to show that only the exact key is accepted.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam logic [7:0] OFS_CTRL   = 8'h00;
    localparam logic [7:0] OFS_PERIOD = 8'h04;
    localparam logic [7:0] OFS_FEED   = 8'h08;
    localparam logic [7:0] OFS_FIRE   = 8'h14;
    localparam logic [7:0] OFS_VEC    = 8'h18;

    localparam logic [7:0]  KEY_CTRL   = 8'h22;
    localparam logic [4:0]  KEY_PERIOD = 5'h08;
    localparam logic [31:0] VAL_FEED   = 32'h0000_1971;
    localparam logic [31:0] VAL_FIRE   = 32'h0000_1209;
    localparam logic [7:0]  KEY_VEC    = 8'h88;

    typedef struct packed {
        logic dual;
        logic autost;
        logic irq_en;
        logic drive;
        logic pol;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
#(
    parameter int LEN_W = 11,
    parameter int NRST  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [7:0]       addr,
    input  logic [31:0]      wdata,
    output ctrl_t            ctrl,
    output logic [LEN_W-1:0] period_nxt,
    output logic [NRST-1:0]  vec,
    output logic [31:0]      rdata,
    output logic             feed_evt,
    output logic             fire_evt,
    output logic             period_evt
);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [LEN_W-1:0]  period;
        logic [NRST-1:0]   vec;
        logic [31:0]       rdata;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        feed_evt   = wr_en && addr == OFS_FEED && wdata == VAL_FEED;
        fire_evt   = wr_en && addr == OFS_FIRE && wdata == VAL_FIRE;
        period_evt = wr_en && addr == OFS_PERIOD && wdata[4:0] == KEY_PERIOD;

        if (wr_en && addr == OFS_CTRL && wdata[31:24] == KEY_CTRL) begin
            st_d.ctrl = '{dual: wdata[6], autost: wdata[4], irq_en: wdata[3],
                          drive: wdata[2], pol: wdata[1], en: wdata[0]};
        end
        if (period_evt) begin
            st_d.period = wdata[5 +: LEN_W];
        end
        if (wr_en && addr == OFS_VEC && wdata[31:24] == KEY_VEC) begin
            st_d.vec = wdata[NRST-1:0];
        end

        if (rd_en) begin
            st_d.rdata = '0;
            case (addr)
                OFS_CTRL:   st_d.rdata[6:0] = {st_q.ctrl.dual, 1'b0, st_q.ctrl.autost,
                                               st_q.ctrl.irq_en, st_q.ctrl.drive,
                                               st_q.ctrl.pol, st_q.ctrl.en};
                OFS_PERIOD: st_d.rdata[5 +: LEN_W] = st_q.period;
                OFS_VEC:    st_d.rdata[NRST-1:0] = st_q.vec;
                default:    st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ctrl: '0, period: '1, vec: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl       = st_q.ctrl;
    assign period_nxt = st_d.period;
    assign vec        = st_q.vec;
    assign rdata      = st_q.rdata;

endmodule

// File: rtl/kwd_count.sv
module kwd_count #(
    parameter int LEN_W   = 11,
    parameter int UNIT_SH = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             dual_arm,
    input  logic             feed,
    input  logic             reload,
    input  logic [LEN_W-1:0] period,
    output logic             irq,
    output logic             bite
);

    localparam int CNT_W = LEN_W + UNIT_SH;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             warned;
        logic             irq;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] load;

    always_comb begin
        load = {period, {UNIT_SH{1'b0}}};
        st_d = st_q;
        bite = 1'b0;
        if (!en) begin
            st_d.cnt    = load;
            st_d.warned = 1'b0;
            st_d.irq    = 1'b0;
        end else if (feed) begin
            st_d.cnt    = load;
            st_d.warned = 1'b0;
            st_d.irq    = 1'b0;
        end else if (reload) begin
            st_d.cnt = load;
        end else if (tick) begin
            if (st_q.cnt <= CNT_W'(1)) begin
                st_d.cnt = load;
                if (dual_arm && !st_q.warned) begin
                    st_d.warned = 1'b1;
                    st_d.irq    = 1'b1;
                end else begin
                    st_d.warned = 1'b0;
                    bite        = 1'b1;
                end
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq = st_q.irq;

endmodule

// File: rtl/kwd_pulse.sv
module kwd_pulse #(
    parameter int PULSE_LEN = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    input  logic drive,
    input  logic pol,
    output logic active,
    output logic rst_out
);

    localparam int PCNT_W = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [PCNT_W-1:0] left;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fire) begin
            st_d.left = PCNT_W'(PULSE_LEN);
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - PCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.left != '0;
    assign rst_out = (drive && active) ? pol : ~pol;

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int LEN_W     = 11,
    parameter int UNIT_SH   = 9,
    parameter int PULSE_LEN = 16,
    parameter int NRST      = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick_en,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [7:0]      addr,
    input  logic [31:0]     wdata,
    output logic [31:0]     rdata,
    output logic            irq,
    output logic            rst_out,
    output logic [NRST-1:0] blk_rst
);

    ctrl_t            ctrl_q;
    logic [LEN_W-1:0] period_nxt;
    logic [NRST-1:0]  vec_q;
    logic             feed_evt;
    logic             fire_evt;
    logic             period_evt;
    logic             bite;
    logic             fire;
    logic             pulse_act;

    kwd_regs #(.LEN_W(LEN_W), .NRST(NRST)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .rd_en      (rd_en),
        .addr       (addr),
        .wdata      (wdata),
        .ctrl       (ctrl_q),
        .period_nxt (period_nxt),
        .vec        (vec_q),
        .rdata      (rdata),
        .feed_evt   (feed_evt),
        .fire_evt   (fire_evt),
        .period_evt (period_evt)
    );

    kwd_count #(.LEN_W(LEN_W), .UNIT_SH(UNIT_SH)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick_en),
        .en       (ctrl_q.en),
        .dual_arm (ctrl_q.dual && ctrl_q.irq_en),
        .feed     (feed_evt),
        .reload   (period_evt),
        .period   (period_nxt),
        .irq      (irq),
        .bite     (bite)
    );

    assign fire = bite || fire_evt;

    kwd_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .drive   (ctrl_q.drive),
        .pol     (ctrl_q.pol),
        .active  (pulse_act),
        .rst_out (rst_out)
    );

    assign blk_rst = vec_q;

endmodule

// File: rtl/keyed_wdog_check.sv
module keyed_wdog_check
    import kwd_pkg::*;
#(
    parameter int PULSE_LEN = 16,
    parameter int NRST      = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [7:0]      addr,
    input logic [31:0]     wdata,
    input logic            irq,
    input ctrl_t           ctrl,
    input logic [NRST-1:0] vec,
    input logic            act,
    input logic            fire
);

    localparam int RUN_W = $clog2(PULSE_LEN + 1);

    logic [RUN_W-1:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= '0;
        end else if (fire || !act) begin
            run <= '0;
        end else begin
            run <= run + RUN_W'(1);
        end
    end

    a_r1_ctrl_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTRL && wdata[31:24] != KEY_CTRL) |=> $stable(ctrl));

    a_r4_feed_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_FEED && wdata == VAL_FEED) |=> !irq);

    a_r5_fire_now: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_FIRE && wdata == VAL_FIRE) |=> act);

    a_r6_irq_needs_dual: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(ctrl.dual && ctrl.irq_en));

    a_r7_disable_clears_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctrl.en) |=> !irq);

    a_r8_pulse_width: assert property (@(posedge clk) disable iff (!rst_n)
        act |-> run < RUN_W'(PULSE_LEN));

    a_r9_vec_key: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_VEC && wdata[31:24] != KEY_VEC) |=> $stable(vec));

endmodule

bind keyed_wdog keyed_wdog_check #(.PULSE_LEN(PULSE_LEN), .NRST(NRST)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .irq   (irq),
    .ctrl  (ctrl_q),
    .vec   (vec_q),
    .act   (pulse_act),
    .fire  (fire)
);

// File: tb/keyed_wdog_test.sv
`timescale 1ns/1ps
module keyed_wdog_test;

    localparam int L = 512;
    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        rst_out;
    logic [15:0] blk_rst;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc++;

    keyed_wdog uut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq), .rst_out(rst_out),
        .blk_rst(blk_rst)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: pops the expected read value queued by the driver
    initial begin
        forever begin
            @(posedge clk);
            if (rd_en) begin
                @(negedge clk);
                if (exp_q.size() == 0) begin
                    check(rdata, 32'hx, "R12 unexpected read");
                end else begin
                    check(rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d, output int e);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
        e = cyc;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        exp_q.push_back(exp); tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic at(input int e, input int k);
        while (cyc < e + k) @(negedge clk);
    endtask

    task automatic pulse_at(input int e, input int k, input logic on, input string tag);
        at(e, k - 1);  check(rst_out, !on, {tag, " before pulse"});
        at(e, k);      check(rst_out, on,  {tag, " pulse start"});
        at(e, k + P - 1); check(rst_out, on, {tag, " pulse last cycle (R8)"});
        at(e, k + P);  check(rst_out, !on, {tag, " pulse end (R8)"});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        int e, e2;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        check(rst_out, 1'b1, "R8 reset: inactive level with polarity low");
        check(irq, 1'b0, "R7 reset irq");
        check(blk_rst, 16'h0, "R9 reset vector");
        rd(8'h00, 32'h0, "R1 control reset value");
        rd(8'h04, 32'h0000_FFE0, "R2 period reset value");

        // R1 keyed control
        wr(8'h00, 32'h2100_0007, e);
        rd(8'h00, 32'h0, "R1 wrong key ignored");
        wr(8'h00, 32'h2200_007F, e);
        rd(8'h00, 32'h0000_005F, "R1 fields stored, bit5 dropped");
        wr(8'h00, 32'h2200_0006, e);
        rd(8'h00, 32'h0000_0006, "R1 rewrite");

        // R2 keyed period
        wr(8'h04, 32'h0000_0047, e);
        rd(8'h04, 32'h0000_FFE0, "R2 wrong low key ignored");
        wr(8'h04, 32'h0000_0028, e);
        rd(8'h04, 32'h0000_0020, "R2 count 1 accepted");

        // R5 immediate fire while disabled
        wr(8'h14, 32'h0000_1208, e);
        at(e, 0); check(rst_out, 1'b0, "R5 near-miss value no pulse");
        at(e, 3); check(rst_out, 1'b0, "R5 near-miss value no pulse later");
        wr(8'h14, 32'h0000_1209, e);
        at(e, 0); check(rst_out, 1'b1, "R5 fire at once");
        at(e, P - 1); check(rst_out, 1'b1, "R8 fire pulse last cycle");
        at(e, P); check(rst_out, 1'b0, "R8 fire pulse end");

        // R3 single-mode expiry
        wr(8'h00, 32'h2200_0007, e);
        pulse_at(e, L, 1'b1, "R3 single expiry");
        check(irq, 1'b0, "R6 no irq in single mode");
        wr(8'h00, 32'h2200_0006, e);
        // R10 disable stops with no reset
        repeat (600) @(negedge clk);
        check(rst_out, 1'b0, "R10 disabled: no expiry");

        // R4 feed
        wr(8'h00, 32'h2200_0007, e);
        at(e, 100);
        wr(8'h08, 32'h0000_1970, e2);
        at(e, 300);
        wr(8'h08, 32'h0000_1971, e2);
        at(e, 400);
        wr(8'h08, 32'h0001_1971, e);
        at(e2, L - 300 + 200);
        check(rst_out, 1'b0, "R4 old deadline passed without reset");
        pulse_at(e2, L, 1'b1, "R4 feed reloads");
        wr(8'h00, 32'h2200_0006, e);

        // R11 period write reloads
        wr(8'h00, 32'h2200_0007, e);
        at(e, 300);
        wr(8'h04, 32'h0000_0028, e2);
        at(e, L);
        check(rst_out, 1'b0, "R11 first deadline moved");
        pulse_at(e2, L, 1'b1, "R11 period write reloads");
        wr(8'h00, 32'h2200_0006, e);

        // R6 dual mode, R7 irq clearing
        wr(8'h00, 32'h2200_004F, e);
        at(e, L - 1); check(irq, 1'b0, "R6 irq before first expiry");
        at(e, L);     check(irq, 1'b1, "R6 irq at first expiry");
        check(rst_out, 1'b0, "R6 no reset at first expiry");
        pulse_at(e, 2 * L, 1'b1, "R6 second expiry resets");
        check(irq, 1'b1, "R7 irq held through reset");
        wr(8'h08, 32'h0000_1971, e);
        at(e, 0); check(irq, 1'b0, "R7 feed clears irq");
        at(e, L); check(irq, 1'b1, "R6 irq again after feed");
        wr(8'h00, 32'h2200_0006, e);
        at(e, 1); check(irq, 1'b0, "R7 disable clears irq");

        // R10 tick gating, full period on enable
        tick_en = 1'b0;
        wr(8'h00, 32'h2200_0007, e);
        at(e, 700); check(rst_out, 1'b0, "R10 no ticks no expiry");
        tick_en = 1'b1;
        e = cyc;
        pulse_at(e, L, 1'b1, "R10 counting starts with ticks");
        wr(8'h00, 32'h2200_0006, e);

        // R8 polarity and drive
        wr(8'h00, 32'h2200_0000, e);
        wr(8'h14, 32'h0000_1209, e);
        at(e, 0); check(rst_out, 1'b1, "R8 drive off: inactive level");
        at(e, P); 
        wr(8'h00, 32'h2200_0004, e);
        wr(8'h14, 32'h0000_1209, e);
        at(e, 0); check(rst_out, 1'b0, "R8 active-low pulse");
        at(e, P - 1); check(rst_out, 1'b0, "R8 active-low last cycle");
        at(e, P); check(rst_out, 1'b1, "R8 active-low release");

        // R9 block reset vector
        wr(8'h18, 32'h8700_1234, e);
        check(blk_rst, 16'h0, "R9 wrong key ignored");
        wr(8'h18, 32'h8800_A5A5, e);
        check(blk_rst, 16'hA5A5, "R9 bits set");
        rd(8'h18, 32'h0000_A5A5, "R9 vector readback, key as zero");
        wr(8'h18, 32'h8800_0001, e);
        check(blk_rst, 16'h0001, "R9 bits released");

        // R12 write-only registers read zero
        rd(8'h08, 32'h0, "R12 feed offset reads zero");
        rd(8'h14, 32'h0, "R12 fire offset reads zero");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

endmodule